// File: doc/BRIEF.md
# Synthesizer Control Word Decoder

This block is the register front end of a direct digital synthesizer. A host writes 16-bit words to it over a serial link in SPI mode 2 (clock idles high, data taken on the falling edge, most significant bit first). Each word sits inside one chip-select window. The serial pins are brought into the system clock domain through synchronizer flops and then oversampled, so the block's own logic runs on the system clock only.

The two top bits of each accepted word choose where the word goes. It can go to the control register, to one of two 28-bit tuning (frequency) words, or to one of two 12-bit phase offsets. A field in the control register sets how a 14-bit frequency payload is merged into its 28-bit target. It can replace the low half only (fine), replace the high half only (coarse), or build the full word from a low and high pair. The register contents are presented continuously to the waveform core, together with the active-register selects, the core reset bit and a decoded waveform mode.

Top module: `dds_word_decoder`

## Requirements
- R1: After reset both frequency words and both phase words read 0, `freqSel`, `phaseSel` and `coreReset` are 0, and `waveMode` is 0 (sine).
- R2: A word is accepted only when exactly 16 falling SCLK edges occur while chip-select is low. The bits are taken most significant first, and the word acts when chip-select rises. A frame with 15 or 17 edges leaves every output unchanged.
- R3: A word with bits 15:14 = 00 loads the control register. Bit 11 drives `freqSel`, bit 10 drives `phaseSel` and bit 8 drives `coreReset`. Bit 13 selects paired mode and bit 12 selects coarse mode.
- R4: `waveMode` is decoded from control bits 5, 3 and 1 as follows. With bit 5 = 0 and bit 1 = 0 it is 0 (sine). With bit 5 = 0 and bit 1 = 1 it is 1 (triangle). With bit 5 = 1, bit 1 = 0 and bit 3 = 1 it is 2 (square at full rate). With bit 5 = 1, bit 1 = 0 and bit 3 = 0 it is 3 (square at half rate). The forbidden case, bit 5 = 1 with bit 1 = 1, gives 0.
- R5: A word with bits 15:14 = 11 writes bits 11:0 to phase word 0 when bit 13 is 0, and to phase word 1 when bit 13 is 1. Bit 12 is ignored, and the frequency words are not touched.
- R6: In fine mode (control bits 13 and 12 both 0), a word with prefix 01 writes its bits 13:0 to bits 13:0 of frequency word 0, and a word with prefix 10 does the same for frequency word 1. Bits 27:14 of the target keep their value.
- R7: In coarse mode (control bit 13 = 0, bit 12 = 1), a frequency word writes its bits 13:0 to bits 27:14 of the target, and bits 13:0 of the target keep their value.
- R8: In paired mode (control bit 13 = 1), the first write to a frequency word is held without changing the output. The next write to the same frequency word supplies bits 27:14, and the whole 28-bit value then updates in one step. Each frequency word keeps its own pairing state, so the writes to the two words may be interleaved.
- R9: Any control word write discards a half-received pair. The next frequency write after it is treated as a first half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spiSclk | input | 1 | Serial clock, idles high |
| spiCsN | input | 1 | Active-low frame select |
| spiMosi | input | 1 | Serial data into the block |
| freqWord0 | output | 28 | Frequency word 0 |
| freqWord1 | output | 28 | Frequency word 1 |
| phaseWord0 | output | 12 | Phase word 0 |
| phaseWord1 | output | 12 | Phase word 1 |
| freqSel | output | 1 | Active frequency word select |
| phaseSel | output | 1 | Active phase word select |
| coreReset | output | 1 | Waveform core reset request |
| waveMode | output | 2 | Decoded waveform mode, 0 sine, 1 triangle, 2 square, 3 half-rate square |

## Verification
The assertions take for granted that the serial pins change slowly compared with the system clock. Each SCLK level and each chip-select level must last several system cycles, so the synchronizers see every edge. They also assume that SCLK is high whenever chip-select changes, and that MOSI is stable before the falling edge that samples it. The stimulus keeps to this: it drives every pin on the falling system-clock edge, holds each SCLK phase for four system cycles, and waits several cycles on both sides of each chip-select transition. After each frame it also leaves a quiet window before the next one.

// File: rtl/dds_dec_pkg.sv
package dds_dec_pkg;

  // Strobes from the serial control to the register datapath.
  typedef struct packed {
    logic shiftBit;   // take one serial bit into the word shifter
    logic bitVal;     // the bit to take
    logic commit;     // a complete, well-formed word is ready
  } dds_strobe_t;

  typedef enum logic [1:0] {
    ROUTE_CTRL  = 2'b00,
    ROUTE_FREQ0 = 2'b01,
    ROUTE_FREQ1 = 2'b10,
    ROUTE_PHASE = 2'b11
  } dds_route_e;

  typedef enum logic [1:0] {
    WAVE_SINE   = 2'd0,
    WAVE_TRI    = 2'd1,
    WAVE_SQUARE = 2'd2,
    WAVE_SQHALF = 2'd3
  } dds_wave_e;

endpackage

// File: rtl/dds_serial_ctrl.sv
module dds_serial_ctrl
  import dds_dec_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        spiSclk,
  input  logic        spiCsN,
  input  logic        spiMosi,
  output dds_strobe_t strb
);

  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

  logic [SYNC_STAGES-1:0] sclkSync;
  logic [SYNC_STAGES-1:0] csSync;
  logic [SYNC_STAGES-1:0] mosiSync;
  logic                   sclkPrev;
  logic                   csPrev;
  logic [CNT_W-1:0]       edgeCount;

  logic sclkNow;
  logic csNow;
  logic mosiNow;
  logic sclkFall;
  logic csRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '1;
      csSync   <= '1;
      mosiSync <= '0;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], spiSclk};
      csSync   <= {csSync[SYNC_STAGES-2:0], spiCsN};
      mosiSync <= {mosiSync[SYNC_STAGES-2:0], spiMosi};
    end
  end

  assign sclkNow  = sclkSync[SYNC_STAGES-1];
  assign csNow    = csSync[SYNC_STAGES-1];
  assign mosiNow  = mosiSync[SYNC_STAGES-1];
  assign sclkFall = sclkPrev & ~sclkNow;
  assign csRise   = ~csPrev & csNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev  <= 1'b1;
      csPrev    <= 1'b1;
      edgeCount <= '0;
      strb      <= '0;
    end else begin
      sclkPrev <= sclkNow;
      csPrev   <= csNow;
      if (csNow) begin
        edgeCount <= '0;
      end else if (sclkFall && (edgeCount != CNT_OVER)) begin
        edgeCount <= edgeCount + 1'b1;
      end
      strb.shiftBit <= sclkFall & ~csNow;
      strb.bitVal   <= mosiNow;
      strb.commit   <= csRise && (edgeCount == CNT_FULL);
    end
  end

endmodule

// File: rtl/dds_reg_datapath.sv
module dds_reg_datapath
  import dds_dec_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int FREQ_W  = 28,
  parameter int PHASE_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  dds_strobe_t        strb,
  output logic [FREQ_W-1:0]  freqOut0,
  output logic [FREQ_W-1:0]  freqOut1,
  output logic [PHASE_W-1:0] phaseOut0,
  output logic [PHASE_W-1:0] phaseOut1,
  output logic               freqSel,
  output logic               phaseSel,
  output logic               coreReset,
  output logic [1:0]         waveMode,
  output logic [WORD_W-1:0]  lastWord,
  output logic [1:0]         pairPend,
  output logic [1:0]         mergeMode
);

  localparam int HALF_W   = FREQ_W / 2;
  localparam int N_FREQ   = 2;
  localparam int N_PHASE  = 2;
  localparam int SEL_BIT  = HALF_W - 1;

  logic [WORD_W-1:0]  shiftReg;
  logic [FREQ_W-1:0]  freqReg  [N_FREQ];
  logic [HALF_W-1:0]  holdLo   [N_FREQ];
  logic               pend     [N_FREQ];
  logic [PHASE_W-1:0] phaseReg [N_PHASE];

  logic pairMode, coarseMode, fSelReg, pSelReg, rstReg;
  logic modeHi, modeMid, modeLo;

  dds_route_e        route;
  logic [HALF_W-1:0] payload;
  logic              ctrlHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.shiftBit) begin
      shiftReg <= {shiftReg[WORD_W-2:0], strb.bitVal};
    end
  end

  assign route   = dds_route_e'(shiftReg[WORD_W-1 -: 2]);
  assign payload = shiftReg[HALF_W-1:0];
  assign ctrlHit = strb.commit && (route == ROUTE_CTRL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pairMode   <= 1'b0;
      coarseMode <= 1'b0;
      fSelReg    <= 1'b0;
      pSelReg    <= 1'b0;
      rstReg     <= 1'b0;
      modeHi     <= 1'b0;
      modeMid    <= 1'b0;
      modeLo     <= 1'b0;
    end else if (ctrlHit) begin
      pairMode   <= payload[13];
      coarseMode <= payload[12];
      fSelReg    <= payload[11];
      pSelReg    <= payload[10];
      rstReg     <= payload[8];
      modeHi     <= payload[5];
      modeMid    <= payload[3];
      modeLo     <= payload[1];
    end
  end

  // One merge engine per frequency word; each keeps its own pairing state.
  for (genvar g = 0; g < N_FREQ; g++) begin : g_freq
    localparam dds_route_e MY_ROUTE = dds_route_e'(g + 1);
    logic freqHit;
    assign freqHit = strb.commit && (route == MY_ROUTE);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        freqReg[g] <= '0;
        holdLo[g]  <= '0;
        pend[g]    <= 1'b0;
      end else if (ctrlHit) begin
        pend[g] <= 1'b0;
      end else if (freqHit) begin
        if (pairMode) begin
          if (!pend[g]) begin
            holdLo[g] <= payload;
            pend[g]   <= 1'b1;
          end else begin
            freqReg[g] <= {payload, holdLo[g]};
            pend[g]    <= 1'b0;
          end
        end else if (coarseMode) begin
          freqReg[g][FREQ_W-1:HALF_W] <= payload;
        end else begin
          freqReg[g][HALF_W-1:0] <= payload;
        end
      end
    end
  end

  for (genvar p = 0; p < N_PHASE; p++) begin : g_phase
    logic phaseHit;
    assign phaseHit = strb.commit && (route == ROUTE_PHASE)
                      && (shiftReg[SEL_BIT] == 1'(p));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        phaseReg[p] <= '0;
      end else if (phaseHit) begin
        phaseReg[p] <= shiftReg[PHASE_W-1:0];
      end
    end
  end

  always_comb begin
    if (modeHi && !modeLo) begin
      waveMode = modeMid ? WAVE_SQUARE : WAVE_SQHALF;
    end else if (modeLo && !modeHi) begin
      waveMode = WAVE_TRI;
    end else begin
      waveMode = WAVE_SINE;
    end
  end

  assign freqOut0  = freqReg[0];
  assign freqOut1  = freqReg[1];
  assign phaseOut0 = phaseReg[0];
  assign phaseOut1 = phaseReg[1];
  assign freqSel   = fSelReg;
  assign phaseSel  = pSelReg;
  assign coreReset = rstReg;
  assign lastWord  = shiftReg;
  assign pairPend  = {pend[1], pend[0]};
  assign mergeMode = {pairMode, coarseMode};

endmodule

// File: rtl/dds_word_decoder.sv
module dds_word_decoder
  import dds_dec_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int FREQ_W      = 28,
  parameter int PHASE_W     = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               spiSclk,
  input  logic               spiCsN,
  input  logic               spiMosi,
  output logic [FREQ_W-1:0]  freqWord0,
  output logic [FREQ_W-1:0]  freqWord1,
  output logic [PHASE_W-1:0] phaseWord0,
  output logic [PHASE_W-1:0] phaseWord1,
  output logic               freqSel,
  output logic               phaseSel,
  output logic               coreReset,
  output logic [1:0]         waveMode
);

  dds_strobe_t       strb;
  logic [WORD_W-1:0] lastWord;
  logic [1:0]        pairPend;
  logic [1:0]        mergeMode;

  dds_serial_ctrl #(
    .WORD_W      (WORD_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .spiSclk (spiSclk),
    .spiCsN  (spiCsN),
    .spiMosi (spiMosi),
    .strb    (strb)
  );

  dds_reg_datapath #(
    .WORD_W  (WORD_W),
    .FREQ_W  (FREQ_W),
    .PHASE_W (PHASE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .freqOut0  (freqWord0),
    .freqOut1  (freqWord1),
    .phaseOut0 (phaseWord0),
    .phaseOut1 (phaseWord1),
    .freqSel   (freqSel),
    .phaseSel  (phaseSel),
    .coreReset (coreReset),
    .waveMode  (waveMode),
    .lastWord  (lastWord),
    .pairPend  (pairPend),
    .mergeMode (mergeMode)
  );

endmodule

// File: rtl/dds_dec_checker.sv
module dds_dec_checker
  import dds_dec_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int FREQ_W  = 28,
  parameter int PHASE_W = 12
) (
  input logic               clk,
  input logic               rstN,
  input dds_strobe_t        strb,
  input logic [WORD_W-1:0]  lastWord,
  input logic [1:0]         pairPend,
  input logic [1:0]         mergeMode,
  input logic [FREQ_W-1:0]  freqWord0,
  input logic [FREQ_W-1:0]  freqWord1,
  input logic [PHASE_W-1:0] phaseWord0,
  input logic [PHASE_W-1:0] phaseWord1,
  input logic [1:0]         waveMode
);

  localparam int HALF_W = FREQ_W / 2;

  logic [1:0] route;
  assign route = lastWord[WORD_W-1 -: 2];

  p_hold_without_commit_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.commit) |-> ($stable(freqWord0) && $stable(freqWord1)
      && $stable(phaseWord0) && $stable(phaseWord1) && $stable(waveMode)));

  p_phase_spares_freq_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.commit && (route == 2'b11)) |-> ($stable(freqWord0) && $stable(freqWord1)));

  p_fine_keeps_upper_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.commit && (route == 2'b01) && (mergeMode == 2'b00))
      |-> (freqWord0[FREQ_W-1:HALF_W] == $past(freqWord0[FREQ_W-1:HALF_W])));

  p_coarse_keeps_lower_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.commit && (route == 2'b10) && (mergeMode == 2'b01))
      |-> (freqWord1[HALF_W-1:0] == $past(freqWord1[HALF_W-1:0])));

  p_first_half_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.commit && (route == 2'b01) && mergeMode[1] && !pairPend[0])
      |-> ($stable(freqWord0) && pairPend[0]));

  p_ctrl_clears_pend_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.commit && (route == 2'b00)) |-> (pairPend == 2'b00));

endmodule

bind dds_word_decoder dds_dec_checker #(
  .WORD_W  (WORD_W),
  .FREQ_W  (FREQ_W),
  .PHASE_W (PHASE_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .strb       (strb),
  .lastWord   (lastWord),
  .pairPend   (pairPend),
  .mergeMode  (mergeMode),
  .freqWord0  (freqWord0),
  .freqWord1  (freqWord1),
  .phaseWord0 (phaseWord0),
  .phaseWord1 (phaseWord1),
  .waveMode   (waveMode)
);

// File: tb/dds_word_decoder_tb.sv
module dds_word_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SCLK_HALF  = 4;
  localparam int SETTLE     = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiSclk = 1'b1;
  logic spiCsN = 1'b1;
  logic spiMosi = 1'b0;

  logic [27:0] freqWord0, freqWord1;
  logic [11:0] phaseWord0, phaseWord1;
  logic        freqSel, phaseSel, coreReset;
  logic [1:0]  waveMode;

  int compared = 0;
  int mismatched = 0;
  bit busy = 1'b1;
  bit done = 1'b0;

  // Reference model state
  logic [27:0] mFreq [2];
  logic [13:0] mHold [2];
  bit          mPend [2];
  logic [11:0] mPhase [2];
  bit mPair, mCoarse, mFsel, mPsel, mRst, mB5, mB3, mB1;

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_word_decoder u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .spiSclk    (spiSclk),
    .spiCsN     (spiCsN),
    .spiMosi    (spiMosi),
    .freqWord0  (freqWord0),
    .freqWord1  (freqWord1),
    .phaseWord0 (phaseWord0),
    .phaseWord1 (phaseWord1),
    .freqSel    (freqSel),
    .phaseSel   (phaseSel),
    .coreReset  (coreReset),
    .waveMode   (waveMode)
  );

  function automatic int expWave();
    if (mB5 && !mB1) return mB3 ? 2 : 3;
    if (mB1 && !mB5) return 1;
    return 0;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 2; i++) begin
      mFreq[i] = 0; mHold[i] = 0; mPend[i] = 0; mPhase[i] = 0;
    end
    {mPair, mCoarse, mFsel, mPsel, mRst, mB5, mB3, mB1} = '0;
  endtask

  task automatic modelApply(input logic [15:0] w);
    int kind;
    int idx;
    logic [13:0] low14;
    kind  = int'(w >> 14);
    low14 = w[13:0];
    if (kind == 0) begin
      mPair = w[13]; mCoarse = w[12]; mFsel = w[11]; mPsel = w[10];
      mRst = w[8]; mB5 = w[5]; mB3 = w[3]; mB1 = w[1];
      mPend[0] = 0; mPend[1] = 0;
    end else if (kind == 3) begin
      mPhase[w[13]] = w % 4096;
    end else begin
      idx = kind - 1;
      if (mPair) begin
        if (!mPend[idx]) begin
          mHold[idx] = low14; mPend[idx] = 1;
        end else begin
          mFreq[idx] = 28'(low14) * 28'd16384 + 28'(mHold[idx]);
          mPend[idx] = 0;
        end
      end else if (mCoarse) begin
        mFreq[idx] = 28'(low14) * 28'd16384 + (mFreq[idx] % 28'd16384);
      end else begin
        mFreq[idx] = (mFreq[idx] / 28'd16384) * 28'd16384 + 28'(low14);
      end
    end
  endtask

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll(input string ctx);
    checkVal({ctx, " R6 R7 R8 freqWord0"}, 32'(freqWord0), 32'(mFreq[0]));
    checkVal({ctx, " R6 R7 R8 freqWord1"}, 32'(freqWord1), 32'(mFreq[1]));
    checkVal({ctx, " R5 phaseWord0"}, 32'(phaseWord0), 32'(mPhase[0]));
    checkVal({ctx, " R5 phaseWord1"}, 32'(phaseWord1), 32'(mPhase[1]));
    checkVal({ctx, " R3 freqSel"}, 32'(freqSel), 32'(mFsel));
    checkVal({ctx, " R3 phaseSel"}, 32'(phaseSel), 32'(mPsel));
    checkVal({ctx, " R3 coreReset"}, 32'(coreReset), 32'(mRst));
    checkVal({ctx, " R4 waveMode"}, 32'(waveMode), 32'(expWave()));
  endtask

  // Per-clock comparison against the model while the link is quiet
  always @(negedge clk) begin
    if (rstN && !busy && !done) compareAll("cycle");
  end

  task automatic sendFrame(input logic [15:0] w, input int nEdges);
    busy = 1'b1;
    @(negedge clk);
    spiCsN = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < nEdges; i++) begin
      spiMosi = (i < 16) ? w[15-i] : 1'b0;
      repeat (SCLK_HALF) @(negedge clk);
      spiSclk = 1'b0;
      repeat (SCLK_HALF) @(negedge clk);
      spiSclk = 1'b1;
    end
    repeat (3) @(negedge clk);
    spiCsN = 1'b1;
    if (nEdges == 16) modelApply(w);
    repeat (SETTLE) @(negedge clk);
    busy = 1'b0;
    @(negedge clk);
  endtask

  task automatic sendWord(input logic [15:0] w);
    sendFrame(w, 16);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state
    checkVal("R1 freqWord0", 32'(freqWord0), 0);
    checkVal("R1 freqWord1", 32'(freqWord1), 0);
    checkVal("R1 phaseWord0", 32'(phaseWord0), 0);
    checkVal("R1 phaseWord1", 32'(phaseWord1), 0);
    checkVal("R1 waveMode", 32'(waveMode), 0);
    checkVal("R1 coreReset", 32'(coreReset), 0);
    busy = 1'b0;

    // R6: fine mode
    sendWord(16'h0000);
    sendWord(16'h4000 | 16'h1234);
    checkVal("R6 fine write freq0", 32'(freqWord0), 32'h0001234);

    // R7: coarse mode
    sendWord(16'h1000);
    sendWord(16'h8000 | 16'h2ABC);
    checkVal("R7 coarse write freq1", 32'(freqWord1), 32'h2ABC << 14);
    sendWord(16'h0000);
    sendWord(16'h8055);
    checkVal("R6 fine keeps upper freq1", 32'(freqWord1), (32'h2ABC << 14) | 32'h55);
    sendWord(16'h1000);
    sendWord(16'h4000 | 16'h0001);
    checkVal("R7 coarse keeps lower freq0", 32'(freqWord0), (32'h1 << 14) | 32'h1234);

    // R8: paired mode, interleaved
    sendWord(16'h2000);
    sendWord(16'h4000 | 16'h0AAA);
    checkVal("R8 first half holds freq0", 32'(freqWord0), (32'h1 << 14) | 32'h1234);
    sendWord(16'h4000 | 16'h1555);
    checkVal("R8 pair completes freq0", 32'(freqWord0), (32'h1555 << 14) | 32'h0AAA);
    sendWord(16'h8000 | 16'h0011);
    sendWord(16'h4000 | 16'h0022);
    sendWord(16'h8000 | 16'h0033);
    checkVal("R8 interleaved freq1", 32'(freqWord1), (32'h33 << 14) | 32'h11);
    checkVal("R8 pending freq0 unchanged", 32'(freqWord0), (32'h1555 << 14) | 32'h0AAA);
    sendWord(16'h4000 | 16'h0044);
    checkVal("R8 interleaved freq0", 32'(freqWord0), (32'h44 << 14) | 32'h22);

    // R9: control write discards a held half
    sendWord(16'h4111);
    sendWord(16'h2000);
    sendWord(16'h4222);
    sendWord(16'h4333);
    checkVal("R9 pair restarted", 32'(freqWord0), (32'h333 << 14) | 32'h222);

    // R5: phase words
    sendWord(16'hC000 | 16'h0ABC);
    checkVal("R5 phase0", 32'(phaseWord0), 32'hABC);
    sendWord(16'hE000 | 16'h1FFF);
    checkVal("R5 phase1 bit12 ignored", 32'(phaseWord1), 32'hFFF);
    sendWord(16'hF123);
    checkVal("R5 phase1 again", 32'(phaseWord1), 32'h123);
    checkVal("R5 freq untouched", 32'(freqWord0), (32'h333 << 14) | 32'h222);

    // R3: control fields
    sendWord(16'h0D00);
    checkVal("R3 freqSel", 32'(freqSel), 1);
    checkVal("R3 phaseSel", 32'(phaseSel), 1);
    checkVal("R3 coreReset", 32'(coreReset), 1);

    // R4: waveform decode
    sendWord(16'h0002);
    checkVal("R4 triangle", 32'(waveMode), 1);
    sendWord(16'h0028);
    checkVal("R4 square", 32'(waveMode), 2);
    sendWord(16'h0020);
    checkVal("R4 half square", 32'(waveMode), 3);
    sendWord(16'h0022);
    checkVal("R4 forbidden gives sine", 32'(waveMode), 0);
    sendWord(16'h000A);
    checkVal("R4 bit3 alone is triangle", 32'(waveMode), 1);

    // R2: malformed frames are ignored
    sendWord(16'h0000);
    sendFrame(16'h4FFF, 15);
    checkVal("R2 short frame ignored", 32'(freqWord0), (32'h333 << 14) | 32'h222);
    sendFrame(16'h4FFF, 17);
    checkVal("R2 long frame ignored", 32'(freqWord0), (32'h333 << 14) | 32'h222);
    sendFrame(16'h0002, 17);
    checkVal("R2 long ctrl ignored", 32'(waveMode), 0);
    sendWord(16'h4FFF);
    checkVal("R2 good frame after bad", 32'(freqWord0), (32'h333 << 14) | 32'h0FFF);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule